// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table and Dispatcher

This block holds a table of interrupt vectors and a pending-bit array inside one 4 KB register window, and turns per-vector interrupt requests into message writes. Every vector owns a 16-byte entry: a 64-bit message address, a 32-bit message data word and a control word whose lowest bit masks the vector. A host reads and writes the entries through a plain 32-bit register port and can read the pending bits, which live in the upper half of the window.

A vector's request input fires on its rising edge. If the vector is masked, the whole function is masked or message signalling is disabled, the vector's pending bit is set and no message goes out. Otherwise the pending bit is cleared and the entry's address and data are sent on a valid/ready message port. Pending vectors are replayed in two ways. A table write re-examines the vector it touched. A rescan pulse from the capability logic walks every vector in ascending order. On both paths a vector is sent only if it is pending, unmasked and allowed to send.

The message port follows valid/ready rules. While `msg_valid` is high and `msg_ready` is low, the address and data hold still. A new message can only be launched in a cycle where the port is empty or being drained. The dispatcher handles one vector per cycle. Captured request edges come first, then write re-checks, then the rescan walk. Nothing is dropped while the port stalls: each source waits in its own per-vector flag.

Top module: `msix_vector_unit`

## Requirements
- R1: Entry v occupies window offsets 16*v to 16*v+15. Its words are address low (+0), address high (+4), data (+8) and vector control (+12), and each reads back exactly as written. The window offset is reg_addr[11:0], and reg_addr[1:0] is ignored.
- R2: A message's 64-bit address is {address high, address low} with bits [1:0] forced to 0. Its data is the entry's data word.
- R3: Bit 0 of vector control masks the vector (1 = masked). The other 31 bits are stored and read back but change nothing.
- R4: Reads at offset 0x800 + 4*w return pending bits 32*w to 32*w+31, with vector v at bit v mod 32. Bits for vectors at or beyond NUM_VEC read 0.
- R5: Writes at offsets 0x800 and above are ignored. Table offsets at or beyond entry NUM_VEC read 0, and writes to them are ignored.
- R6: Only a 0-to-1 transition of irq_req[v] raises a request, so holding the level high sends one message. An unmasked, enabled request sends one message and clears the pending bit.
- R7: A request that arrives while the vector is masked, func_mask is 1 or enable is 0 sets the pending bit, and no message is sent.
- R8: After a write to any word of entry v, vector v is re-checked. If it is pending and it is unmasked with enable=1 and func_mask=0, its message is sent and its pending bit is cleared.
- R9: A rescan pulse checks vectors 0 to NUM_VEC-1 in ascending order using the R8 rule. Replayed messages therefore leave in ascending vector order.
- R10: After reset all table words and pending bits read 0, and msg_valid is 0.
- R11: While msg_valid=1 and msg_ready=0, msg_valid, msg_addr and msg_data hold. Requests that arrive during a stall are all sent afterwards, in ascending vector order when they arrive together.
- R12: No message is launched unless enable was 1 and func_mask was 0 in the launch cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset in the window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| enable | input | 1 | Message signalling enabled |
| func_mask | input | 1 | Function-wide mask |
| rescan | input | 1 | Pulse: replay pending vectors |
| irq_req | input | NUM_VEC | Per-vector request levels |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
Single requests on unmasked vectors check that the address and data are formed correctly. A request level held high checks that only the edge counts. Requests on a vector-masked, function-masked or disabled vector must be parked in the pending bits rather than sent. Each way of releasing a parked vector is tried on its own — unmasking it with a table write, or a rescan after clearing the function mask or enabling — so a design that replays on the wrong trigger is exposed. Two simultaneous requests under back-pressure check both message stability and ordering. Writes to the pending region and past the last entry must leave readback at zero.

// File: rtl/msix_pkg.sv
package msix_pkg;
  localparam int WIN_AW   = 12;
  localparam int MAX_VEC  = 128;   // table half of the window holds 128 entries
  localparam int ENT_W    = 7;     // entry index bits of an offset
  localparam int PBA_SEL  = 11;    // offset bit that selects the pending half

  typedef enum logic [1:0] {
    K_NONE,
    K_RISE,
    K_CHK,
    K_SCAN
  } work_kind_e;
endpackage

// File: rtl/msix_window.sv
module msix_window
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int IDX_W   = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_en,
  input  logic                  reg_we,
  input  logic [WIN_AW-1:0]     reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic [NUM_VEC-1:0]    pend,
  input  logic [IDX_W-1:0]      sel_idx,
  output logic [63:0]           sel_addr,
  output logic [31:0]           sel_data,
  output logic                  sel_mask,
  output logic                  wr_pulse,
  output logic [IDX_W-1:0]      wr_idx
);
  logic [31:0] tbl [NUM_VEC][4];
  logic        in_table;
  logic        wr_ok;
  logic [31:0] rd_mux;

  assign in_table = !reg_addr[PBA_SEL] && (32'(reg_addr[ENT_W+3:4]) < NUM_VEC);
  assign wr_ok    = reg_en && reg_we && in_table;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < NUM_VEC; e++)
        for (int w = 0; w < 4; w++)
          tbl[e][w] <= '0;
      wr_pulse <= 1'b0;
      wr_idx   <= '0;
    end else begin
      if (wr_ok)
        tbl[reg_addr[4 +: IDX_W]][reg_addr[3:2]] <= reg_wdata;
      wr_pulse <= wr_ok;
      if (wr_ok)
        wr_idx <= reg_addr[4 +: IDX_W];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (!reg_addr[PBA_SEL]) begin
      if (in_table)
        rd_mux = tbl[reg_addr[4 +: IDX_W]][reg_addr[3:2]];
    end else begin
      for (int b = 0; b < 32; b++) begin
        if (32 * int'(reg_addr[PBA_SEL-1:2]) + b < NUM_VEC)
          rd_mux[b] = pend[IDX_W'(32 * int'(reg_addr[PBA_SEL-1:2]) + b)];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      reg_rdata <= '0;
    else if (reg_en && !reg_we)
      reg_rdata <= rd_mux;
  end

  assign sel_addr = {tbl[sel_idx][1], tbl[sel_idx][0][31:2], 2'b00};
  assign sel_data = tbl[sel_idx][2];
  assign sel_mask = tbl[sel_idx][3][0];

  // R5
  pba_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && reg_we && reg_addr[PBA_SEL]) |=> !wr_pulse);

  // R8
  wr_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> $past(reg_en) && $past(reg_we));
endmodule

// File: rtl/msix_dispatch.sv
module msix_dispatch
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int IDX_W   = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_VEC-1:0]    irq_req,
  input  logic                  enable,
  input  logic                  func_mask,
  input  logic                  rescan,
  input  logic                  wr_pulse,
  input  logic [IDX_W-1:0]      wr_idx,
  output logic [IDX_W-1:0]      sel_idx,
  input  logic [63:0]           sel_addr,
  input  logic [31:0]           sel_data,
  input  logic                  sel_mask,
  output logic [NUM_VEC-1:0]    pend,
  output logic                  msg_valid,
  input  logic                  msg_ready,
  output logic [63:0]           msg_addr,
  output logic [31:0]           msg_data
);
  localparam logic [NUM_VEC-1:0] ONE = {{(NUM_VEC-1){1'b0}}, 1'b1};

  logic [NUM_VEC-1:0] req_d, rise_q, chk_q, pend_q, sel_oh, wr_oh;
  logic               scan_on;
  logic [IDX_W-1:0]   scan_idx;
  work_kind_e         kind;
  logic               out_free, blocked, act, send, park;

  function automatic logic [IDX_W-1:0] lowest(input logic [NUM_VEC-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--)
      if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  always_comb begin
    if (|rise_q) begin
      kind    = K_RISE;
      sel_idx = lowest(rise_q);
    end else if (|chk_q) begin
      kind    = K_CHK;
      sel_idx = lowest(chk_q);
    end else if (scan_on) begin
      kind    = K_SCAN;
      sel_idx = scan_idx;
    end else begin
      kind    = K_NONE;
      sel_idx = '0;
    end
  end

  assign out_free = !msg_valid || msg_ready;
  assign blocked  = !enable || func_mask || sel_mask;
  assign act      = out_free && (kind != K_NONE);
  assign send     = act && !blocked && ((kind == K_RISE) || pend_q[sel_idx]);
  assign park     = act && blocked && (kind == K_RISE);
  assign sel_oh   = ONE << sel_idx;
  assign wr_oh    = wr_pulse ? (ONE << wr_idx) : '0;
  assign pend     = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_d    <= '0;
      rise_q   <= '0;
      chk_q    <= '0;
      pend_q   <= '0;
      scan_on  <= 1'b0;
      scan_idx <= '0;
      msg_valid <= 1'b0;
      msg_addr <= '0;
      msg_data <= '0;
    end else begin
      req_d  <= irq_req;
      rise_q <= (rise_q & ~((act && kind == K_RISE) ? sel_oh : '0)) | (irq_req & ~req_d);
      chk_q  <= (chk_q & ~((act && kind == K_CHK) ? sel_oh : '0)) | wr_oh;
      if (send)
        pend_q <= pend_q & ~sel_oh;
      else if (park)
        pend_q <= pend_q | sel_oh;
      if (rescan) begin
        scan_on  <= 1'b1;
        scan_idx <= '0;
      end else if (act && kind == K_SCAN) begin
        if (32'(scan_idx) == NUM_VEC - 1)
          scan_on <= 1'b0;
        else
          scan_idx <= scan_idx + 1'b1;
      end
      if (out_free) begin
        msg_valid <= send;
        if (send) begin
          msg_addr <= sel_addr;
          msg_data <= sel_data;
        end
      end
    end
  end

  // R11
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  // R2
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_addr[1:0] == 2'b00));

  // R12
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> ($past(enable) && !$past(func_mask)));

  // R6
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send |=> !pend_q[$past(sel_idx)] && msg_valid);

  // R7
  park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    park |=> pend_q[$past(sel_idx)] && !msg_valid);

  // R9
  scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && kind == K_SCAN && !rescan && 32'(scan_idx) != NUM_VEC - 1)
      |=> scan_idx == $past(scan_idx) + 1'b1);
endmodule

// File: rtl/msix_vector_unit.sv
module msix_vector_unit
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_en,
  input  logic                reg_we,
  input  logic [11:0]         reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic                enable,
  input  logic                func_mask,
  input  logic                rescan,
  input  logic [NUM_VEC-1:0]  irq_req,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [63:0]         msg_addr,
  output logic [31:0]         msg_data
);
  localparam int IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  logic [NUM_VEC-1:0] pend;
  logic [IDX_W-1:0]   sel_idx, wr_idx;
  logic [63:0]        sel_addr;
  logic [31:0]        sel_data;
  logic               sel_mask, wr_pulse;

  initial begin
    if (NUM_VEC < 2 || NUM_VEC > MAX_VEC)
      $error("NUM_VEC out of range");
  end

  msix_window #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_window (
    .clk(clk), .rst_n(rst_n),
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pend(pend), .sel_idx(sel_idx),
    .sel_addr(sel_addr), .sel_data(sel_data), .sel_mask(sel_mask),
    .wr_pulse(wr_pulse), .wr_idx(wr_idx)
  );

  msix_dispatch #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_dispatch (
    .clk(clk), .rst_n(rst_n),
    .irq_req(irq_req), .enable(enable), .func_mask(func_mask), .rescan(rescan),
    .wr_pulse(wr_pulse), .wr_idx(wr_idx),
    .sel_idx(sel_idx), .sel_addr(sel_addr), .sel_data(sel_data), .sel_mask(sel_mask),
    .pend(pend),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );
endmodule

// File: tb/msix_vector_unit_test.sv
module msix_vector_unit_test;
  localparam int NV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_en = 1'b0, reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic enable = 1'b0, func_mask = 1'b0, rescan = 1'b0;
  logic [NV-1:0] irq_req = '0;
  logic msg_valid, msg_ready = 1'b1;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  string cur_req = "R10";
  logic [95:0] exp_q[$];

  always #5 clk = ~clk;

  msix_vector_unit #(.NUM_VEC(NV)) uut (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .enable(enable), .func_mask(func_mask), .rescan(rescan), .irq_req(irq_req),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  function automatic logic [31:0] lo_of(int v); return 32'hFEE0_0003 + 32'(v << 4); endfunction
  function automatic logic [31:0] hi_of(int v); return 32'h0000_0010 + 32'(v); endfunction
  function automatic logic [31:0] dat_of(int v); return 32'h0000_4000 + 32'(v); endfunction
  function automatic logic [95:0] exp_of(int v);
    return {hi_of(v), lo_of(v) & 32'hFFFF_FFFC, dat_of(v)};
  endfunction

  task automatic check(bit ok, string req, logic [95:0] act, logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected messages as handshakes are about to complete
  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready && !finished) begin
      if (exp_q.size() == 0)
        check(0, cur_req, {msg_addr, msg_data}, '0);
      else begin
        logic [95:0] e;
        e = exp_q.pop_front();
        check({msg_addr, msg_data} == e, cur_req, {msg_addr, msg_data}, e);
      end
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_en = 1'b0;
    check(reg_rdata == exp, req, 96'(reg_rdata), 96'(exp));
  endtask

  task automatic pulse(logic [NV-1:0] m);
    @(negedge clk); irq_req = irq_req | m;
    @(negedge clk); irq_req = irq_req & ~m;
  endtask

  task automatic do_rescan();
    @(negedge clk); rescan = 1'b1;
    @(negedge clk); rescan = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 100 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (12) @(negedge clk);
    check(exp_q.size() == 0, cur_req, 96'(exp_q.size()), 96'd0);
    exp_q.delete();
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state
    check(msg_valid == 1'b0, "R10", 96'(msg_valid), 96'd0);
    rd(12'h030, 32'h0, "R10");
    rd(12'h800, 32'h0, "R10");

    // R1: program and read back
    cur_req = "R1";
    for (int v = 0; v < NV; v++) begin
      wr(12'(v * 16 + 0), lo_of(v));
      wr(12'(v * 16 + 4), hi_of(v));
      wr(12'(v * 16 + 8), dat_of(v));
    end
    rd(12'h030, lo_of(3), "R1");
    rd(12'h034, hi_of(3), "R1");
    rd(12'h03B, dat_of(3), "R1");
    rd(12'h03C, 32'h0, "R1");

    // R2, R6: single unmasked request
    enable = 1'b1;
    cur_req = "R2";
    exp_q.push_back(exp_of(2));
    pulse(8'h04);
    drain();

    // R6: level held high gives one message
    cur_req = "R6";
    exp_q.push_back(exp_of(6));
    @(negedge clk); irq_req[6] = 1'b1;
    repeat (15) @(negedge clk);
    irq_req[6] = 1'b0;
    drain();

    // R3: other control bits have no effect
    cur_req = "R3";
    wr(12'h07C, 32'hFFFF_FFFE);
    rd(12'h07C, 32'hFFFF_FFFE, "R3");
    exp_q.push_back(exp_of(7));
    pulse(8'h80);
    drain();

    // R7, R4: masked vector parks
    cur_req = "R7";
    wr(12'h05C, 32'h0000_0001);
    pulse(8'h20);
    drain();
    rd(12'h800, 32'h0000_0020, "R4");

    // R5: pending region is read-only
    cur_req = "R5";
    wr(12'h800, 32'hFFFF_FFFF);
    rd(12'h800, 32'h0000_0020, "R5");

    // R8: unmask via table write replays
    cur_req = "R8";
    exp_q.push_back(exp_of(5));
    wr(12'h05C, 32'h0000_0000);
    drain();
    rd(12'h800, 32'h0, "R8");

    // R9: function mask, then ordered rescan
    cur_req = "R7";
    func_mask = 1'b1;
    pulse(8'h42);
    drain();
    rd(12'h800, 32'h0000_0042, "R7");
    @(negedge clk); func_mask = 1'b0;
    repeat (5) @(negedge clk);
    check(msg_valid == 1'b0, "R9", 96'(msg_valid), 96'd0);
    cur_req = "R9";
    exp_q.push_back(exp_of(1));
    exp_q.push_back(exp_of(6));
    do_rescan();
    drain();
    rd(12'h800, 32'h0, "R9");

    // R12: disabled parks, enable plus rescan sends
    cur_req = "R12";
    enable = 1'b0;
    pulse(8'h01);
    drain();
    rd(12'h800, 32'h0000_0001, "R12");
    @(negedge clk); enable = 1'b1;
    exp_q.push_back(exp_of(0));
    do_rescan();
    drain();

    // R11: back-pressure with two simultaneous requests
    cur_req = "R11";
    @(negedge clk); msg_ready = 1'b0;
    exp_q.push_back(exp_of(3));
    exp_q.push_back(exp_of(4));
    pulse(8'h18);
    repeat (8) @(negedge clk);
    check(msg_valid == 1'b1, "R11", 96'(msg_valid), 96'd1);
    check({msg_addr, msg_data} == exp_of(3), "R11", {msg_addr, msg_data}, exp_of(3));
    msg_ready = 1'b1;
    drain();

    // R5: beyond the last entry
    cur_req = "R5";
    wr(12'h080, 32'h1234_5678);
    rd(12'h080, 32'h0, "R5");
    rd(12'h7F0, 32'h0, "R5");

    finish_up();
  end
endmodule